// File: doc/BRIEF.md
# Measurement Start and Trigger Controller

This block holds an 8-bit control register and a small sequencer. Together they decide when a repeating capacitive sensing measurement runs. Software writes the register through a simple write strobe with data and reads it back on a parallel read bus.

A single start bit serves two purposes, selected by a trigger-select bit:

- **Software mode.** Setting start launches one measurement at once. The start bit clears itself when that measurement completes.
- **External mode.** Setting start arms the unit. Each rising edge of a synchronized external trigger then launches a measurement. After every measurement the unit returns to waiting, and start stays set.

The measurement engine outside this block receives a run level and answers with a one-cycle done pulse. The block reports a 3-bit state code and a one-cycle completion pulse. It also drives two outputs from the register: the level for the transmit pins, and a low-power-wait enable that is valid only while armed. An initialize command, written together with start at 0, is the one way to stop a running unit. It also emits a clear strobe for the neighbouring status and channel registers.

Top module: `sense_start_ctrl`

## Requirements
- R1: Register readback is {3'b000, 1'b0, tx_hi(bit3), lp_en(bit2), ext_mode(bit1), start(bit0)`}`. Bits 7..5 and the initialize bit (bit4) always read 0. The transmit level bit (bit3) is writable at any time, and `tx_level` follows it.
- R2: After reset, `rd_data` is 8'h00, `state` is 3'b000, and `meas_run`, `lp_wait`, `meas_cmplt`, `tx_level` and `clr_pulse` are all 0.
- R3: In software mode (bit1 = 0), a write with bit0 = 1 while start is 0 has these effects. In the cycle after the write, `state` is 3'b001 and `meas_run` is 1. From the following cycle `state` is 3'b010 and stays there until `meas_done`.
- R4: In software mode, the start bit reads 0 in the cycle after the completion cycle, and `state` returns to 3'b000.
- R5: In external mode (bit1 = 1), setting start leaves `state` at 3'b000 with start reading 1. A rising edge on `ext_trig`, after a two-flop synchronizer, then launches a measurement (`state` 3'b001, then 3'b010).
- R6: In external mode, after each completion the unit returns to waiting (`state` 3'b000) with start still 1. The next trigger edge launches another measurement.
- R7: A write with bit0 = 1 while start is 1 does not disturb the measurement in progress or the waiting state.
- R8: Bits 1 and 2 take their written value only when start is 0 before the write, which includes the same write that sets start. While start is 1, writes to them are ignored.
- R9: A write with bit4 = 1 and bit0 = 0 forces a stop. In the next cycle start is 0, `state` is 3'b000 and `meas_run` is 0, whatever the prior state.
- R10: Trigger edges that arrive while a measurement is running are dropped, not queued.
- R11: `lp_wait` is 1 only while lp_en is 1 and the unit is armed and waiting for a trigger.
- R12: `meas_cmplt` is a one-cycle pulse in the cycle after `meas_done` is accepted during a measurement. In that cycle `state` is 3'b011.
- R13: A forced-stop/initialize write produces a one-cycle `clr_pulse` in the cycle after the write.
- R14: A write with bit0 = 0 and bit4 = 0 while start is 1 leaves start at 1 and the operation running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| ext_trig | input | 1 | Asynchronous external trigger |
| meas_done | input | 1 | One-cycle done pulse from the measurement engine |
| state | output | 3 | State code, non-zero while measuring |
| meas_run | output | 1 | Request to the engine to measure |
| tx_level | output | 1 | Transmit pin drive level |
| lp_wait | output | 1 | Low-power-wait enable |
| meas_cmplt | output | 1 | One-cycle measurement-complete pulse |
| clr_pulse | output | 1 | Clear strobe for neighbouring status and channel registers |

## Verification
The bound checker covers the rules that hold on every cycle:

- the reserved and initialize bits read zero;
- a running measurement always shows a non-zero state code;
- `lp_wait` appears only while armed;
- the mode bits stay frozen while start is set;
- self-clearing in software mode and re-arming in external mode after each completion;
- the outcome of a forced stop;
- the single-cycle completion pulse.

The directed scenarios show what only a sequence of events can reveal:

- the exact launch latency and the order of state codes;
- a trigger edge that is dropped because a measurement is running, seen as the unit idling afterwards;
- rewrites of start that are ignored, with the measurement still finishing normally;
- a forced stop while armed that leaves later trigger edges with no effect.

// File: rtl/sense_ctrl_pkg.sv
package sense_ctrl_pkg;

    localparam int REG_W   = 8;
    localparam int CODE_W  = 3;

    // Bit positions of the control register (software-visible layout)
    localparam int B_START = 0;
    localparam int B_EXT   = 1;
    localparam int B_LPEN  = 2;
    localparam int B_TXHI  = 3;
    localparam int B_INIT  = 4;

    typedef enum logic [2:0] {
        PH_STOP   = 3'd0,
        PH_ARM    = 3'd1,
        PH_LAUNCH = 3'd2,
        PH_ACTIVE = 3'd3,
        PH_END    = 3'd4
    } phase_e;

    typedef struct packed {
        logic tx_hi;
        logic lp_en;
        logic ext_mode;
        logic start;
    } ctrl_s;

    typedef struct packed {
        logic valid;
        logic init;
        logic tx_hi;
        logic lp_en;
        logic ext_mode;
        logic start;
    } wr_cmd_s;

    function automatic wr_cmd_s decode_write(input logic en, input logic [REG_W-1:0] d);
        wr_cmd_s c;
        c.valid    = en;
        c.init     = d[B_INIT];
        c.tx_hi    = d[B_TXHI];
        c.lp_en    = d[B_LPEN];
        c.ext_mode = d[B_EXT];
        c.start    = d[B_START];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input ctrl_s c);
        logic [REG_W-1:0] r;
        r           = '0;
        r[B_START]  = c.start;
        r[B_EXT]    = c.ext_mode;
        r[B_LPEN]   = c.lp_en;
        r[B_TXHI]   = c.tx_hi;
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] state_code(input phase_e p);
        case (p)
            PH_LAUNCH: return 3'b001;
            PH_ACTIVE: return 3'b010;
            PH_END:    return 3'b011;
            default:   return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/sense_trig_sync.sv
module sense_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/sense_ctrl_reg.sv
module sense_ctrl_reg
    import sense_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_s cmd,
    input  logic    seq_clr_start,
    output ctrl_s   ctrl,
    output logic    arm_req,
    output logic    arm_ext,
    output logic    force_stop,
    output logic    init_pulse
);
    logic init_q;

    assign force_stop = cmd.valid & cmd.init & ~cmd.start;
    assign arm_req    = cmd.valid & cmd.start & ~ctrl.start;
    // Mode used for a fresh start comes from the same write
    assign arm_ext    = ctrl.start ? ctrl.ext_mode : cmd.ext_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            init_q <= 1'b0;
        end else begin
            init_q <= force_stop;
            if (cmd.valid) begin
                ctrl.tx_hi <= cmd.tx_hi;
                if (!ctrl.start) begin
                    ctrl.ext_mode <= cmd.ext_mode;
                    ctrl.lp_en    <= cmd.lp_en;
                end
            end
            if (force_stop)         ctrl.start <= 1'b0;
            else if (arm_req)       ctrl.start <= 1'b1;
            else if (seq_clr_start) ctrl.start <= 1'b0;
        end
    end

    assign init_pulse = init_q;
endmodule

// File: rtl/sense_seq.sv
module sense_seq
    import sense_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   arm_req,
    input  logic   arm_ext,
    input  logic   force_stop,
    input  logic   ext_mode,
    input  logic   trig_rise,
    input  logic   meas_done,
    output phase_e phase,
    output logic   clr_start
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        if (force_stop) begin
            nxt = PH_STOP;
        end else begin
            case (phase)
                PH_STOP:   if (arm_req) nxt = arm_ext ? PH_ARM : PH_LAUNCH;
                PH_ARM:    if (trig_rise) nxt = PH_LAUNCH;
                PH_LAUNCH: nxt = PH_ACTIVE;
                PH_ACTIVE: if (meas_done) nxt = PH_END;
                PH_END:    nxt = ext_mode ? PH_ARM : PH_STOP;
                default:   nxt = PH_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_STOP;
        else     phase <= nxt;
    end

    assign clr_start = (phase == PH_END) & ~ext_mode;
endmodule

// File: rtl/sense_start_ctrl.sv
module sense_start_ctrl
    import sense_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ext_trig,
    input  logic              meas_done,
    output logic [CODE_W-1:0] state,
    output logic              meas_run,
    output logic              tx_level,
    output logic              lp_wait,
    output logic              meas_cmplt,
    output logic              clr_pulse
);
    wr_cmd_s cmd;
    ctrl_s   ctrl;
    phase_e  phase;
    logic    arm_req, arm_ext, force_stop, clr_start, trig_rise;

    assign cmd = decode_write(wr_en, wr_data);

    sense_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_trig), .rise(trig_rise)
    );

    sense_ctrl_reg u_reg (
        .clk(clk), .rst(rst), .cmd(cmd), .seq_clr_start(clr_start),
        .ctrl(ctrl), .arm_req(arm_req), .arm_ext(arm_ext),
        .force_stop(force_stop), .init_pulse(clr_pulse)
    );

    sense_seq u_seq (
        .clk(clk), .rst(rst), .arm_req(arm_req), .arm_ext(arm_ext),
        .force_stop(force_stop), .ext_mode(ctrl.ext_mode),
        .trig_rise(trig_rise), .meas_done(meas_done),
        .phase(phase), .clr_start(clr_start)
    );

    assign rd_data    = pack_read(ctrl);
    assign state      = state_code(phase);
    assign meas_run   = (phase == PH_LAUNCH) | (phase == PH_ACTIVE);
    assign meas_cmplt = (phase == PH_END);
    assign lp_wait    = ctrl.lp_en & (phase == PH_ARM);
    assign tx_level   = ctrl.tx_hi;
endmodule

// File: rtl/sense_start_ctrl_chk.sv
module sense_start_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] state,
    input logic       meas_run,
    input logic       lp_wait,
    input logic       meas_cmplt
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:4] == 4'b0000);                                          // R1
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        meas_run |-> state != 3'b000);                                     // R3
    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (meas_cmplt && !rd_data[1]) |=> !rd_data[0]);                      // R4
    AST_EXT_REARM: assert property (@(posedge clk) disable iff (rst)
        (meas_cmplt && rd_data[1] && !(wr_en && wr_data[4] && !wr_data[0]))
        |=> (rd_data[0] && state == 3'b000));                              // R6
    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] |=> $stable(rd_data[2:1]));                             // R8
    AST_FORCED_STOP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4] && !wr_data[0])
        |=> (!rd_data[0] && state == 3'b000 && !meas_run));                // R9
    AST_LPW_ARMED: assert property (@(posedge clk) disable iff (rst)
        lp_wait |-> (state == 3'b000 && rd_data[0] && rd_data[1] && rd_data[2])); // R11
    AST_CMPLT_PULSE: assert property (@(posedge clk) disable iff (rst)
        meas_cmplt |-> (state == 3'b011 && !meas_run));                   // R12
    AST_CMPLT_ONE: assert property (@(posedge clk) disable iff (rst)
        meas_cmplt |=> !meas_cmplt);                                       // R12
endmodule

bind sense_start_ctrl sense_start_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .state(state), .meas_run(meas_run),
    .lp_wait(lp_wait), .meas_cmplt(meas_cmplt)
);

// File: tb/sense_start_ctrl_test.sv
module sense_start_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_trig = 1'b0;
    logic       meas_done;
    logic [2:0] state;
    logic       meas_run, tx_level, lp_wait, meas_cmplt, clr_pulse;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sense_start_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_trig(ext_trig), .meas_done(meas_done),
        .state(state), .meas_run(meas_run), .tx_level(tx_level),
        .lp_wait(lp_wait), .meas_cmplt(meas_cmplt), .clr_pulse(clr_pulse)
    );

    // Engine stub: done after LAT cycles of run
    int eng_cnt;
    always_ff @(posedge clk) begin
        if (rst || !meas_run) eng_cnt <= 0;
        else                  eng_cnt <= eng_cnt + 1;
    end
    assign meas_done = meas_run && (eng_cnt == LAT);

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic pulse_trig();
        @(negedge clk); ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic wait_cmplt(input string req);
        int n = 0;
        while (!meas_cmplt && n < 200) begin @(negedge clk); n++; end
        check(req, "completion seen", int'(meas_cmplt), 1);
        check("R12", "state at completion", int'(state), 3);
    endtask

    task automatic wait_state(input logic [2:0] s, input string req);
        int n = 0;
        while (state != s && n < 50) begin @(negedge clk); n++; end
        check(req, "reached state", int'(state), int'(s));
    endtask

    task automatic stop_all();
        wr(8'h10);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R2", "rd_data", int'(rd_data), 0);
        check("R2", "state", int'(state), 0);
        check("R2", "outputs", int'({meas_run, lp_wait, meas_cmplt, tx_level, clr_pulse}), 0);
    endtask

    task automatic t_layout();
        wr(8'hF8);
        check("R1", "reserved/init read 0", int'(rd_data), 8'h08);
        check("R1", "tx_level", int'(tx_level), 1);
        wr(8'h06);
        check("R1", "mode bits readback", int'(rd_data), 8'h06);
        check("R1", "tx_level low", int'(tx_level), 0);
        wr(8'h00);
    endtask

    task automatic t_sw_run();
        wr(8'h01);
        check("R3", "launch state", int'(state), 1);
        check("R3", "run", int'(meas_run), 1);
        @(negedge clk);
        check("R3", "active state", int'(state), 2);
        wait_cmplt("R3");
        @(negedge clk);
        check("R4", "self clear start", int'(rd_data[0]), 0);
        check("R4", "state stopped", int'(state), 0);
        repeat (3) @(negedge clk);
        check("R4", "stays stopped", int'(state), 0);
    endtask

    task automatic t_rewrite();
        wr(8'h01);
        wait_state(3'd2, "R7");
        wr(8'h07);
        check("R7", "still active", int'(state), 2);
        check("R8", "mode bits locked", int'(rd_data), 8'h01);
        wr(8'h00);
        check("R14", "start kept", int'(rd_data[0]), 1);
        check("R14", "still active", int'(state), 2);
        wait_cmplt("R7");
        @(negedge clk);
        check("R4", "sw mode kept, cleared", int'(rd_data[0]), 0);
    endtask

    task automatic t_ext();
        wr(8'h07);
        check("R8", "mode set with start", int'(rd_data), 8'h07);
        check("R5", "armed state", int'(state), 0);
        check("R11", "lp_wait armed", int'(lp_wait), 1);
        repeat (5) @(negedge clk);
        check("R5", "waits without trigger", int'(state), 0);
        pulse_trig();
        wait_state(3'd1, "R5");
        check("R11", "lp_wait off while measuring", int'(lp_wait), 0);
        @(negedge clk);
        check("R5", "active", int'(state), 2);
        pulse_trig();
        wait_cmplt("R6");
        @(negedge clk);
        check("R6", "re-armed state", int'(state), 0);
        check("R6", "start stays", int'(rd_data[0]), 1);
        begin
            int busy = 0;
            repeat (25) begin @(negedge clk); if (state != 0) busy++; end
            check("R10", "dropped edge not queued", busy, 0);
        end
        pulse_trig();
        wait_state(3'd1, "R6");
        wait_cmplt("R6");
        @(negedge clk);
        check("R6", "re-armed again", int'(rd_data[0]), 1);
        wr(8'h10);
        check("R9", "forced stop while armed", int'(rd_data[0]), 0);
        check("R13", "clear strobe", int'(clr_pulse), 1);
        check("R11", "lp_wait off stopped", int'(lp_wait), 0);
        @(negedge clk);
        check("R13", "strobe one cycle", int'(clr_pulse), 0);
        pulse_trig();
        repeat (6) @(negedge clk);
        check("R9", "trigger ignored after stop", int'(state), 0);
        wr(8'h00);
    endtask

    task automatic t_force_run();
        wr(8'h01);
        wait_state(3'd2, "R9");
        wr(8'h10);
        check("R9", "state", int'(state), 0);
        check("R9", "run", int'(meas_run), 0);
        check("R9", "start", int'(rd_data[0]), 0);
        repeat (LAT + 4) @(negedge clk);
        check("R9", "no completion after stop", int'(state), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_sw_run();
        t_rewrite();
        t_ext();
        stop_all();
        t_force_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule